// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block is the front end of one display DMA channel. Each time a frame starts, it reads a four-word frame descriptor from memory. The descriptor supplies the next descriptor pointer, the frame source address, a frame identifier and a command word. The pointer taken from each descriptor is the address used at the following frame, so descriptors form a linked list that the channel walks one frame at a time. Software can override that list for a single frame through a branch register. The request bit in the branch register clears itself once the branch is taken.

Once the descriptor is loaded, the block checks the source address. A source that passes the check is handed to the pixel mover together with the transfer length and the palette flag. The block then waits for the mover's completion strobe. Single-cycle event strobes report:
- start of frame
- end of frame
- a branch that was taken
- a bus error, together with the channel number
- the last frame before a requested stop

Software configures the block and reads its state back through a small word-addressed register port.

Top module: `fdf_engine`

## Requirements
- R1: After reset:
  - every register reads back zero;
  - `rd_valid` is low;
  - no event strobe is asserted.
- R2: Register writes are masked as follows:
  - A write to the pointer register (address 1) stores the value with bits 3:0 forced to zero.
  - A write to the branch register (address 2) keeps only the bits under 0xFFFFFFF3.
  - Writes to the read-only registers (3 source, 4 frame ID, 5 command) are ignored.
- R3: An accepted frame start issues exactly four single-word reads, at pointer, pointer+4, pointer+8 and pointer+12. The four words load, in order, the next pointer (bits 3:0 cleared), the source, the frame ID and the command.
- R4: Branch behaviour:
  - If branch bit 0 is set when a frame is accepted, the fetch starts at branch bits 31:4 (low nibble zero) and bit 0 clears.
  - `ev_branch` pulses in that cycle only if branch bit 1 is also set.
- R5: If the 16-byte descriptor does not fit inside the memory window [MEM_BASE, MEM_BASE+MEM_SIZE), no read is issued, the source register reads zero, and a bus error follows.
- R6: If the source is zero or lies above MEM_BASE+MEM_SIZE (or below MEM_BASE), the frame is skipped:
  - `ev_bus_err` pulses with `ev_err_chan` equal to CHAN_ID;
  - there is no `xfer_start`, no start-of-frame event and no end-of-frame event.
- R7: `ev_sof` pulses in the same cycle as `xfer_start`, and only when command bit 22 is set.
- R8: `ev_eof` pulses in the cycle `xfer_done` is seen, and only when command bit 21 is set.
- R9: While `xfer_start` is high:
  - `xfer_addr` equals the source;
  - `xfer_len` equals command bits 20:2 with bits 1:0 zero;
  - `xfer_palette` equals command bit 26.
- R10: With control bit 1 (stop after frame) set, the end of a frame clears control bit 0 (run) and pulses `ev_last_frame`.
- R11: `frame_start` has no effect while control bit 0 is clear, or while a frame is still in progress.
- R12: While `rd_valid` is high and `rd_ready` is low, the request is held with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0 control, 1 pointer, 2 branch, 3 source, 4 frame ID, 5 command) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at reg_addr |
| frame_start | input | 1 | Frame start pulse |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | 32 | Memory read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| xfer_start | output | 1 | Start pixel transfer |
| xfer_addr | output | 32 | Transfer source address |
| xfer_len | output | 21 | Transfer length in bytes |
| xfer_palette | output | 1 | Transfer is a palette load |
| xfer_done | input | 1 | Pixel transfer complete |
| ev_sof | output | 1 | Start-of-frame event |
| ev_eof | output | 1 | End-of-frame event |
| ev_branch | output | 1 | Branch-taken event |
| ev_bus_err | output | 1 | Bus error event |
| ev_err_chan | output | CHAN_W | Channel number reported with a bus error |
| ev_last_frame | output | 1 | Last frame done after a stop request |

## Verification
The embedded properties check several rules on every cycle:
- a stalled read holds its address;
- every issued read lies inside the memory window;
- a taken branch clears its request bit;
- a stop request clears the run bit;
- a transfer never starts from a zero source;
- a bus error never coincides with a transfer start or a start-of-frame event.

Only the directed scenarios can show the rest:
- the order and contents of the four descriptor reads;
- the linked-list walk across frames;
- which command bits gate each event;
- boundary placement of descriptors at the window edge;
- clearing of the source register on a skipped fetch;
- frame starts being ignored mid-frame or while stopped.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int DW = 32;
  localparam int RAW = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_CHECK, S_XFER, S_FINISH
  } fdf_state_e;

  localparam logic [RAW-1:0] REG_CTRL   = 3'd0;
  localparam logic [RAW-1:0] REG_NEXT   = 3'd1;
  localparam logic [RAW-1:0] REG_BRANCH = 3'd2;
  localparam logic [RAW-1:0] REG_SRC    = 3'd3;
  localparam logic [RAW-1:0] REG_FID    = 3'd4;
  localparam logic [RAW-1:0] REG_CMD    = 3'd5;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_STOP = 1;
  localparam int BR_REQ    = 0;
  localparam int BR_INT    = 1;
  localparam int CMD_EOF   = 21;
  localparam int CMD_SOF   = 22;
  localparam int CMD_PAL   = 26;
  localparam int LEN_W     = 21;

  localparam logic [DW-1:0] ALIGN_MASK  = 32'hFFFF_FFF0;
  localparam logic [DW-1:0] BRANCH_MASK = 32'hFFFF_FFF3;

  localparam logic [1:0] W_NEXT = 2'd0;
  localparam logic [1:0] W_SRC  = 2'd1;
  localparam logic [1:0] W_FID  = 2'd2;
  localparam logic [1:0] W_CMD  = 2'd3;
endpackage

// File: rtl/fdf_window.sv
module fdf_window #(
  parameter logic [31:0] BASE = 32'h8000_0000,
  parameter logic [31:0] SIZE = 32'h0000_4000,
  parameter int          SPAN = 0
) (
  input  logic [31:0] addr_i,
  output logic        ok_o
);
  localparam logic [33:0] LO  = {2'b00, BASE};
  localparam logic [33:0] LIM = {2'b00, BASE} + {2'b00, SIZE};

  logic [33:0] lo_w;
  logic [33:0] hi_w;

  always_comb begin
    lo_w = {2'b00, addr_i};
    hi_w = lo_w + 34'(SPAN);
    ok_o = (lo_w >= LO) && (hi_w <= LIM);
  end
endmodule

// File: rtl/fdf_regs.sv
module fdf_regs
  import fdf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_wr_i,
  input  logic [RAW-1:0] sw_addr_i,
  input  logic [DW-1:0]  sw_wdata_i,
  output logic [DW-1:0]  sw_rdata_o,
  input  logic           start_i,
  input  logic           word_vld_i,
  input  logic [1:0]     word_idx_i,
  input  logic [DW-1:0]  word_i,
  input  logic           clr_run_i,
  output logic           run_o,
  output logic           stop_o,
  output logic [DW-1:0]  next_o,
  output logic           br_req_o,
  output logic           br_int_o,
  output logic [DW-5:0]  br_addr_o,
  output logic [DW-1:0]  src_o,
  output logic           sof_en_o,
  output logic           eof_en_o,
  output logic           pal_o,
  output logic [LEN_W-1:0] len_o
);
  logic run_q, run_n, stop_q, stop_n;
  logic [DW-1:0] next_q, next_n, br_q, br_n, src_q, src_n;
  logic [DW-1:0] fid_q, fid_n, cmd_q, cmd_n;
  logic          upd_en;

  always_comb begin
    run_n  = run_q;
    stop_n = stop_q;
    next_n = next_q;
    br_n   = br_q;
    src_n  = src_q;
    fid_n  = fid_q;
    cmd_n  = cmd_q;
    if (sw_wr_i) begin
      case (sw_addr_i)
        REG_CTRL: begin
          run_n  = sw_wdata_i[CTRL_RUN];
          stop_n = sw_wdata_i[CTRL_STOP];
        end
        REG_NEXT:   next_n = sw_wdata_i & ALIGN_MASK;
        REG_BRANCH: br_n   = sw_wdata_i & BRANCH_MASK;
        default: ;
      endcase
    end
    if (start_i) begin
      src_n = '0;
      if (br_q[BR_REQ]) br_n[BR_REQ] = 1'b0;
    end
    if (word_vld_i) begin
      case (word_idx_i)
        W_NEXT:  next_n = word_i & ALIGN_MASK;
        W_SRC:   src_n  = word_i;
        W_FID:   fid_n  = word_i;
        default: cmd_n  = word_i;
      endcase
    end
    if (clr_run_i) run_n = 1'b0;
  end

  assign upd_en = sw_wr_i | start_i | word_vld_i | clr_run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      next_q <= '0;
      br_q   <= '0;
      src_q  <= '0;
      fid_q  <= '0;
      cmd_q  <= '0;
    end else if (upd_en) begin
      run_q  <= run_n;
      stop_q <= stop_n;
      next_q <= next_n;
      br_q   <= br_n;
      src_q  <= src_n;
      fid_q  <= fid_n;
      cmd_q  <= cmd_n;
    end
  end

  always_comb begin
    case (sw_addr_i)
      REG_CTRL:   sw_rdata_o = {{(DW-2){1'b0}}, stop_q, run_q};
      REG_NEXT:   sw_rdata_o = next_q;
      REG_BRANCH: sw_rdata_o = br_q;
      REG_SRC:    sw_rdata_o = src_q;
      REG_FID:    sw_rdata_o = fid_q;
      REG_CMD:    sw_rdata_o = cmd_q;
      default:    sw_rdata_o = '0;
    endcase
  end

  assign run_o     = run_q;
  assign stop_o    = stop_q;
  assign next_o    = next_q;
  assign br_req_o  = br_q[BR_REQ];
  assign br_int_o  = br_q[BR_INT];
  assign br_addr_o = br_q[DW-1:4];
  assign src_o     = src_q;
  assign sof_en_o  = cmd_q[CMD_SOF];
  assign eof_en_o  = cmd_q[CMD_EOF];
  assign pal_o     = cmd_q[CMD_PAL];
  assign len_o     = {cmd_q[LEN_W-1:2], 2'b00};

  // R4: a taken branch drops its request bit
  p_branch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && br_q[BR_REQ] && !(sw_wr_i && sw_addr_i == REG_BRANCH))
    |=> !br_q[BR_REQ]);

  // R10: a stop at frame end clears the run bit
  p_stop_clears_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run_i && !(sw_wr_i && sw_addr_i == REG_CTRL)) |=> !run_q);
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0000_4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          stop_i,
  input  logic          frame_start_i,
  input  logic          br_req_i,
  input  logic          br_int_i,
  input  logic [DW-1:0] ptr_sel_i,
  input  logic          desc_ok_i,
  input  logic [DW-1:0] src_i,
  input  logic          src_ok_i,
  input  logic          sof_en_i,
  input  logic          eof_en_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_addr_o,
  input  logic          rsp_valid_i,
  input  logic          xfer_done_i,
  output logic          start_o,
  output logic          word_vld_o,
  output logic [1:0]    word_idx_o,
  output logic          clr_run_o,
  output logic          xfer_start_o,
  output logic          ev_sof_o,
  output logic          ev_eof_o,
  output logic          ev_branch_o,
  output logic          ev_berr_o,
  output logic          ev_last_o
);
  fdf_state_e    state_q, state_n;
  logic [DW-1:0] ptr_q, ptr_n;
  logic [1:0]    idx_q, idx_n;

  always_comb begin
    state_n      = state_q;
    ptr_n        = ptr_q;
    idx_n        = idx_q;
    rd_valid_o   = 1'b0;
    start_o      = 1'b0;
    word_vld_o   = 1'b0;
    clr_run_o    = 1'b0;
    xfer_start_o = 1'b0;
    ev_sof_o     = 1'b0;
    ev_eof_o     = 1'b0;
    ev_branch_o  = 1'b0;
    ev_berr_o    = 1'b0;
    ev_last_o    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (run_i && frame_start_i) begin
          start_o     = 1'b1;
          ev_branch_o = br_req_i & br_int_i;
          ptr_n       = ptr_sel_i;
          idx_n       = '0;
          state_n     = desc_ok_i ? S_REQ : S_CHECK;
        end
      end
      S_REQ: begin
        rd_valid_o = 1'b1;
        if (rd_ready_i) state_n = S_WAIT;
      end
      S_WAIT: begin
        if (rsp_valid_i) begin
          word_vld_o = 1'b1;
          if (idx_q == W_CMD) begin
            state_n = S_CHECK;
          end else begin
            idx_n   = idx_q + 2'd1;
            state_n = S_REQ;
          end
        end
      end
      S_CHECK: begin
        if ((src_i != '0) && src_ok_i) begin
          xfer_start_o = 1'b1;
          ev_sof_o     = sof_en_i;
          state_n      = S_XFER;
        end else begin
          ev_berr_o = 1'b1;
          state_n   = S_FINISH;
        end
      end
      S_XFER: begin
        if (xfer_done_i) begin
          ev_eof_o = eof_en_i;
          state_n  = S_FINISH;
        end
      end
      default: begin
        if (stop_i) begin
          clr_run_o = 1'b1;
          ev_last_o = 1'b1;
        end
        state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      if (start_o) ptr_q <= ptr_n;
      if (start_o || word_vld_o) idx_q <= idx_n;
    end
  end

  assign rd_addr_o  = ptr_q + {{(DW-4){1'b0}}, idx_q, 2'b00};
  assign word_idx_o = idx_q;

  // R12: stalled request holds
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  // R5: reads stay inside the memory window
  p_rd_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (({2'b00, rd_addr_o} >= {2'b00, MEM_BASE}) &&
                    ({2'b00, rd_addr_o} + 34'd4 <= {2'b00, MEM_BASE} + {2'b00, MEM_SIZE})));
endmodule

// File: rtl/fdf_engine.sv
module fdf_engine
  import fdf_pkg::*;
#(
  parameter int          CHAN_W   = 3,
  parameter int          CHAN_ID  = 5,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              frame_start,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_addr,
  input  logic              rsp_valid,
  input  logic [DW-1:0]     rsp_data,
  output logic              xfer_start,
  output logic [DW-1:0]     xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_palette,
  input  logic              xfer_done,
  output logic              ev_sof,
  output logic              ev_eof,
  output logic              ev_branch,
  output logic              ev_bus_err,
  output logic [CHAN_W-1:0] ev_err_chan,
  output logic              ev_last_frame
);
  localparam int DESC_BYTES = 16;
  localparam logic [CHAN_W-1:0] CHAN_CODE = CHAN_W'(CHAN_ID);

  logic          run, stop, br_req, br_int, sof_en, eof_en, pal;
  logic [DW-1:0] next_ptr, src, ptr_sel;
  logic [DW-5:0] br_addr;
  logic [LEN_W-1:0] len;
  logic          desc_ok, src_ok;
  logic          start, word_vld, clr_run;
  logic [1:0]    word_idx;

  assign ptr_sel = br_req ? {br_addr, 4'b0000} : next_ptr;

  fdf_regs u_regs (
    .clk, .rst_n,
    .sw_wr_i(reg_wr), .sw_addr_i(reg_addr), .sw_wdata_i(reg_wdata),
    .sw_rdata_o(reg_rdata),
    .start_i(start), .word_vld_i(word_vld), .word_idx_i(word_idx),
    .word_i(rsp_data), .clr_run_i(clr_run),
    .run_o(run), .stop_o(stop), .next_o(next_ptr),
    .br_req_o(br_req), .br_int_o(br_int), .br_addr_o(br_addr),
    .src_o(src), .sof_en_o(sof_en), .eof_en_o(eof_en), .pal_o(pal), .len_o(len)
  );

  fdf_window #(.BASE(MEM_BASE), .SIZE(MEM_SIZE), .SPAN(DESC_BYTES)) u_desc_win (
    .addr_i(ptr_sel), .ok_o(desc_ok)
  );

  fdf_window #(.BASE(MEM_BASE), .SIZE(MEM_SIZE), .SPAN(0)) u_src_win (
    .addr_i(src), .ok_o(src_ok)
  );

  fdf_seq #(.MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_seq (
    .clk, .rst_n,
    .run_i(run), .stop_i(stop), .frame_start_i(frame_start),
    .br_req_i(br_req), .br_int_i(br_int), .ptr_sel_i(ptr_sel),
    .desc_ok_i(desc_ok), .src_i(src), .src_ok_i(src_ok),
    .sof_en_i(sof_en), .eof_en_i(eof_en),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rsp_valid_i(rsp_valid), .xfer_done_i(xfer_done),
    .start_o(start), .word_vld_o(word_vld), .word_idx_o(word_idx),
    .clr_run_o(clr_run), .xfer_start_o(xfer_start),
    .ev_sof_o(ev_sof), .ev_eof_o(ev_eof), .ev_branch_o(ev_branch),
    .ev_berr_o(ev_bus_err), .ev_last_o(ev_last_frame)
  );

  assign xfer_addr    = src;
  assign xfer_len     = len;
  assign xfer_palette = pal;
  assign ev_err_chan  = ev_bus_err ? CHAN_CODE : '0;

  // R6: a transfer never starts from a null source
  p_xfer_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_addr != '0));

  // R6: an error frame carries no transfer and no start-of-frame
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |-> (!xfer_start && !ev_sof));
endmodule

// File: tb/tb_fdf_engine.sv
module tb_fdf_engine;
  localparam logic [31:0] B = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic frame_start = 1'b0;
  logic rd_valid, rd_ready, rsp_valid;
  logic [31:0] rd_addr, rsp_data;
  logic xfer_start, xfer_palette, xfer_done;
  logic [31:0] xfer_addr;
  logic [20:0] xfer_len;
  logic ev_sof, ev_eof, ev_branch, ev_bus_err, ev_last_frame;
  logic [2:0] ev_err_chan;

  always #2.5 clk = ~clk;

  fdf_engine dut (.*);

  logic [31:0] mem [0:255];
  logic [1:0] rdy_cnt;
  logic [2:0] dcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0; rd_ready <= 1'b0; rdy_cnt <= '0;
      xfer_done <= 1'b0; dcnt <= '0;
    end else begin
      rdy_cnt  <= rdy_cnt + 2'd1;
      rd_ready <= (rdy_cnt != 2'd3);
      rsp_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ((rd_addr - B) < 32'd1024) ? mem[(rd_addr - B) >> 2] : 32'h0;
      end
      xfer_done <= 1'b0;
      if (xfer_start) dcnt <= 3'd3;
      else if (dcnt != 0) begin
        dcnt <= dcnt - 3'd1;
        if (dcnt == 3'd1) xfer_done <= 1'b1;
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  int n_rd, n_sof, n_eof, n_br, n_berr, n_xfer, n_last;
  int t_sof, t_xs, t_done, t_eof;
  logic [31:0] rd_log [0:7];
  logic [31:0] x_addr;
  logic [20:0] x_len;
  logic x_pal;
  logic [2:0] berr_ch;
  logic ev_seen;

  always @(negedge clk) begin
    cyc++;
    if (rd_valid && rd_ready) begin
      if (n_rd < 8) rd_log[n_rd] = rd_addr;
      n_rd++;
    end
    if (ev_sof) begin n_sof++; t_sof = cyc; end
    if (ev_eof) begin n_eof++; t_eof = cyc; end
    if (ev_branch) n_br++;
    if (ev_bus_err) begin n_berr++; berr_ch = ev_err_chan; end
    if (ev_last_frame) n_last++;
    if (xfer_done) t_done = cyc;
    if (xfer_start) begin
      n_xfer++; t_xs = cyc; x_addr = xfer_addr; x_len = xfer_len; x_pal = xfer_palette;
    end
    if (ev_sof | ev_eof | ev_branch | ev_bus_err | ev_last_frame | rd_valid) ev_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_rd = 0; n_sof = 0; n_eof = 0; n_br = 0; n_berr = 0; n_xfer = 0; n_last = 0;
    t_sof = -1; t_xs = -2; t_done = -3; t_eof = -4; berr_ch = '0; ev_seen = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic frame(input bit extra_start);
    clr_mon();
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    if (extra_start) begin
      repeat (3) @(posedge clk);
      #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
    end
    repeat (60) @(posedge clk);
  endtask

  task automatic put_desc(input int off, input logic [31:0] w0, w1, w2, w3);
    mem[off/4] = w0; mem[off/4+1] = w1; mem[off/4+2] = w2; mem[off/4+3] = w3;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    clr_mon();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset readback reg %0d", a), v, 32'h0);
    end
    chk("R1 no request or event after reset", {31'b0, ev_seen}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd1, B + 32'h107); rd(3'd1, v);
    chk("R2 pointer low nibble cleared", v, B + 32'h100);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v);
    chk("R2 branch mask", v, 32'hFFFF_FFF3);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1234_5678); rd(3'd3, v);
    chk("R2 source read-only", v, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v);
    chk("R2 command read-only", v, 32'h0);
  endtask

  task automatic t_disabled();
    wr(3'd1, B + 32'h40);
    frame(1'b0);
    chk("R11 no reads while stopped", n_rd, 0);
    chk("R11 no transfer while stopped", n_xfer, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    frame(1'b0);
    chk("R3 four reads", n_rd, 4);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R3 read address %0d", i), rd_log[i], B + 32'h40 + 32'(4*i));
    rd(3'd1, v); chk("R3 next pointer loaded and aligned", v, B + 32'h80);
    rd(3'd3, v); chk("R3 source loaded", v, B + 32'h2000);
    rd(3'd4, v); chk("R3 frame id loaded", v, 32'h1234);
    rd(3'd5, v); chk("R3 command loaded", v, 32'h047F_FFFF);
    chk("R7 sof fires", n_sof, 1);
    chk("R7 sof with transfer start", t_sof, t_xs);
    chk("R8 eof fires", n_eof, 1);
    chk("R8 eof at completion", t_eof, t_done);
    chk("R9 transfer address", x_addr, B + 32'h2000);
    chk("R9 transfer length", {11'b0, x_len}, 32'h001F_FFFC);
    chk("R9 palette flag", {31'b0, x_pal}, 32'h1);
    chk("R12 exactly four accepted reads under stalls", n_rd, 4);
  endtask

  task automatic t_gated_busy();
    frame(1'b1);
    chk("R11 mid-frame start ignored (reads)", n_rd, 4);
    chk("R11 mid-frame start ignored (transfers)", n_xfer, 1);
    chk("R7 sof gated off", n_sof, 0);
    chk("R8 eof gated off", n_eof, 0);
    chk("R9 plain length", {11'b0, x_len}, 32'h40);
    chk("R9 palette clear", {31'b0, x_pal}, 32'h0);
    chk("R3 linked walk first read", rd_log[0], B + 32'h80);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    wr(3'd2, B + 32'hC3);
    frame(1'b0);
    chk("R4 fetch at branch address", rd_log[0], B + 32'hC0);
    chk("R4 branch event with interrupt bit", n_br, 1);
    rd(3'd2, v); chk("R4 request bit self-clears", v, B + 32'hC2);
    chk("R8 eof only", n_eof, 1);
    chk("R7 no sof", n_sof, 0);
    wr(3'd2, B + 32'h41);
    frame(1'b0);
    chk("R4 branch without interrupt fetch", rd_log[0], B + 32'h40);
    chk("R4 no branch event", n_br, 0);
    rd(3'd1, v); chk("R4 chain continues from branch target", v, B + 32'h80);
  endtask

  task automatic t_bad_src();
    logic [31:0] v;
    wr(3'd1, B + 32'h100);
    frame(1'b0);
    chk("R6 zero source bus error", n_berr, 1);
    chk("R6 channel number", {29'b0, berr_ch}, 32'd5);
    chk("R6 no transfer", n_xfer, 0);
    chk("R6 no sof/eof", n_sof + n_eof, 0);
    frame(1'b0);
    chk("R6 out-of-window source bus error", n_berr, 1);
    chk("R6 out-of-window no transfer", n_xfer, 0);
    rd(3'd3, v); chk("R6 source held", v, B + 32'h4004);
  endtask

  task automatic t_bad_desc();
    logic [31:0] v;
    wr(3'd1, 32'h1000_0000);
    frame(1'b0);
    chk("R5 no read outside window", n_rd, 0);
    rd(3'd3, v); chk("R5 source cleared", v, 32'h0);
    chk("R5 bus error", n_berr, 1);
    wr(3'd1, B + 32'h4000);
    frame(1'b0);
    chk("R5 descriptor past window end", n_rd, 0);
    wr(3'd1, B + 32'h3FF0);
    frame(1'b0);
    chk("R5 last descriptor that fits is read", n_rd, 4);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(3'd1, B + 32'h40);
    wr(3'd0, 32'h3);
    frame(1'b0);
    chk("R10 last frame event", n_last, 1);
    chk("R10 frame still transfers", n_xfer, 1);
    rd(3'd0, v); chk("R10 run cleared, stop kept", v, 32'h2);
    frame(1'b0);
    chk("R11 stopped channel ignores start", n_rd, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(32'h40, B + 32'h85, B + 32'h2000, 32'h1234, 32'h047F_FFFF);
    put_desc(32'h80, B + 32'h40, B + 32'h3000, 32'h2, 32'h0000_0040);
    put_desc(32'hC0, B + 32'h100, B + 32'h1000, 32'h7, 32'h0020_0080);
    put_desc(32'h100, B + 32'h140, 32'h0, 32'h9, 32'h0060_0010);
    put_desc(32'h140, B + 32'h40, B + 32'h4004, 32'hA, 32'h0060_0010);
    clr_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_basic();
    t_gated_busy();
    t_branch();
    t_bad_src();
    t_bad_desc();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule